// File: doc/BRIEF.md
# CAN Identifier Arbitration Unit

This unit settles who owns a CAN bus when several nodes begin a frame together. It drives the node's 11-bit identifier onto the bus, highest bit first, and then the remote-request flag. Once per bit, on the sample strobe, it compares the level it is driving with the level the open-collector bus returns. The bus is the AND of all drivers, so 0 (dominant) overrides 1 (recessive). When the node drives recessive but reads dominant, it has met a more urgent frame. It then releases the line at once, latches a loss flag and records the position of that bit. When the remote-request bit is sampled with no loss, the node owns the bus and raises a win flag. Stuffing, checksums and the data phase belong to other blocks.

The unit also watches the sampled bus for a run of recessive bits that marks an idle bus. A start request is accepted only while that idle condition holds. An accepted start clears the previous outcome and loads the shifter. The control is a four-state machine:
- **READY** waits for a start while the bus is idle.
- **ARB** drives and compares bits.
- **LOST** and **WON** hold the outcome.

The transitions are:
- READY/LOST/WON → ARB on an accepted start.
- ARB → LOST on a recessive-driven, dominant-read sample.
- ARB → WON on a clean sample of the final (remote-request) bit.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, bus_tx is 1 (recessive), lost and won are 0, lost_idx is 0 and bus_idle is 0.
- R2: bus_idle rises on the sample strobe that completes IDLE_BITS (default 11) consecutive recessive samples. A dominant sample clears the run. A start_req while bus_idle is 0 is ignored, and bus_tx stays 1.
- R3: After an accepted start, bus_tx presents identifier bit ID_W-1 down to bit 0, then the remote-request bit. It advances by one position per sample strobe and holds between strobes.
- R4: A sample with bus_tx = 1 and bus_rx = 0 sets lost and records lost_idx. For an identifier bit, lost_idx is that bit's number (ID_W-1 .. 0). For the remote-request bit, lost_idx is ID_W (11). From then on bus_tx stays 1.
- R5: A sample with bus_tx = 0 never causes a loss. When competitors are present, the node whose {identifier, remote-request} value is numerically lowest finishes with won = 1. A tie also finishes with won = 1.
- R6: With equal identifiers, a data frame (remote-request 0) wins over a remote frame (remote-request 1), and the remote frame loses with lost_idx = 11.
- R7: A lone transmitter always reads back its own bits and finishes with won = 1, whatever its identifier.
- R8: lost, won and lost_idx hold through later sample strobes until the next accepted start, which clears all three.
- R9: lost and won are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_pt | input | 1 | One-cycle strobe at each bit's sample point |
| start_req | input | 1 | Request to begin arbitration |
| frame_id | input | ID_W | Identifier to send, captured on an accepted start |
| rtr_flag | input | 1 | Remote-request bit (1 = remote frame) |
| bus_rx | input | 1 | Bus level read back, valid with smp_pt |
| bus_tx | output | 1 | Level driven to the bus (1 = released) |
| bus_idle | output | 1 | Idle run detected |
| lost | output | 1 | Arbitration lost (latched) |
| won | output | 1 | Arbitration won (latched) |
| lost_idx | output | $clog2(ID_W+1) | Position of the losing bit |

## Verification
The bench builds the unit with its defaults: an 11-bit identifier and an 11-bit idle run. With these values every identifier position 10..0 and the remote-request slot (index 11) are reachable as loss points, and the exact 10-versus-11 idle boundary can be tested. A bench-side competitor backs off under the same wired-AND rule as the design. This covers a loss on the first bit, in the middle and on the last bit, on the remote-request bit, ties, and a lone node.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ARB   = 2'd1,
        ST_LOST  = 2'd2,
        ST_WON   = 2'd3
    } arb_state_t;
endpackage

// File: rtl/can_idle_det.sv
module can_idle_det #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_pt,
    input  logic bus_rx,
    output logic bus_idle
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (smp_pt) begin
            if (!bus_rx) begin
                run_cnt <= '0;
            end else if (run_cnt != RUN_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign bus_idle = (run_cnt == RUN_MAX);
endmodule

// File: rtl/can_arb_seq.sv
module can_arb_seq #(
    parameter int ID_W  = 11,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             rtr_flag,
    output logic             cur_bit,
    output logic [IDX_W-1:0] cur_idx,
    output logic             last_bit
);
    localparam int SH_W = ID_W + 1;
    localparam logic [IDX_W-1:0] RTR_POS = IDX_W'(ID_W);
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(ID_W - 1);

    logic [SH_W-1:0]  shreg;
    logic [IDX_W-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            pos   <= '0;
        end else if (load) begin
            shreg <= {frame_id, rtr_flag};
            pos   <= '0;
        end else if (adv) begin
            shreg <= {shreg[SH_W-2:0], 1'b1};
            pos   <= pos + 1'b1;
        end
    end

    assign cur_bit  = shreg[SH_W-1];
    assign last_bit = (pos == RTR_POS);
    assign cur_idx  = (pos < RTR_POS) ? (TOP_BIT - pos) : RTR_POS;
endmodule

// File: rtl/can_arb_fsm.sv
module can_arb_fsm
    import can_arb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_pt,
    input  logic             start_req,
    input  logic             bus_idle,
    input  logic             bus_rx,
    input  logic             cur_bit,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             last_bit,
    output logic             load,
    output logic             adv,
    output logic             drive_en,
    output logic             lost,
    output logic             won,
    output logic [IDX_W-1:0] lost_idx
);
    arb_state_t state, nxt;
    logic       start_ok;
    logic       clash;

    assign start_ok = (state != ST_ARB) && start_req && bus_idle;
    assign clash    = (state == ST_ARB) && smp_pt && cur_bit && !bus_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARB: begin
                if (clash) begin
                    nxt = ST_LOST;
                end else if (smp_pt && last_bit) begin
                    nxt = ST_WON;
                end
            end
            ST_READY, ST_LOST, ST_WON: begin
                if (start_ok) begin
                    nxt = ST_ARB;
                end
            end
            default: nxt = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_idx <= '0;
        end else if (start_ok) begin
            lost_idx <= '0;
        end else if (clash) begin
            lost_idx <= cur_idx;
        end
    end

    always_comb begin
        load     = start_ok;
        adv      = (state == ST_ARB) && smp_pt && !clash && !last_bit;
        drive_en = (state == ST_ARB);
        lost     = (state == ST_LOST);
        won      = (state == ST_WON);
    end
endmodule

// File: rtl/can_arb_unit.sv
module can_arb_unit #(
    parameter int ID_W      = 11,
    parameter int IDLE_BITS = 11,
    localparam int IDX_W    = $clog2(ID_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_pt,
    input  logic             start_req,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             rtr_flag,
    input  logic             bus_rx,
    output logic             bus_tx,
    output logic             bus_idle,
    output logic             lost,
    output logic             won,
    output logic [IDX_W-1:0] lost_idx
);
    logic             load, adv, drive_en;
    logic             cur_bit, last_bit;
    logic [IDX_W-1:0] cur_idx;
    logic             arb_active;

    can_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_pt   (smp_pt),
        .bus_rx   (bus_rx),
        .bus_idle (bus_idle)
    );

    can_arb_seq #(.ID_W(ID_W), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .frame_id (frame_id),
        .rtr_flag (rtr_flag),
        .cur_bit  (cur_bit),
        .cur_idx  (cur_idx),
        .last_bit (last_bit)
    );

    can_arb_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_pt    (smp_pt),
        .start_req (start_req),
        .bus_idle  (bus_idle),
        .bus_rx    (bus_rx),
        .cur_bit   (cur_bit),
        .cur_idx   (cur_idx),
        .last_bit  (last_bit),
        .load      (load),
        .adv       (adv),
        .drive_en  (drive_en),
        .lost      (lost),
        .won       (won),
        .lost_idx  (lost_idx)
    );

    assign arb_active = drive_en;
    assign bus_tx     = drive_en ? cur_bit : 1'b1;
endmodule

// File: rtl/can_arb_chk.sv
module can_arb_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_pt,
    input logic             start_req,
    input logic             bus_rx,
    input logic             bus_tx,
    input logic             bus_idle,
    input logic             lost,
    input logic             won,
    input logic [IDX_W-1:0] lost_idx,
    input logic             arb_active
);
    // R2: arbitration begins only from an accepted start on an idle bus
    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_active) |-> $past(start_req && bus_idle));

    // R2: a dominant sample breaks the idle run
    assert_dominant_clears_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_pt && !bus_rx) |=> !bus_idle);

    // R3: the driven bit only moves on a sample strobe
    assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_active && !smp_pt) |=> $stable(bus_tx));

    // R4: a loss only follows a recessive-driven, dominant-read sample
    assert_loss_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(smp_pt && bus_tx && !bus_rx));

    // R4: a losing node releases the bus
    assert_lost_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> bus_tx);

    // R8: outcome and index hold until a new accepted start
    assert_lost_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !(start_req && bus_idle)) |=> (lost && $stable(lost_idx)));

    assert_won_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (won && !(start_req && bus_idle)) |=> won);

    // R9: outcomes exclusive
    assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(lost && won));
endmodule

bind can_arb_unit can_arb_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_pt     (smp_pt),
    .start_req  (start_req),
    .bus_rx     (bus_rx),
    .bus_tx     (bus_tx),
    .bus_idle   (bus_idle),
    .lost       (lost),
    .won        (won),
    .lost_idx   (lost_idx),
    .arb_active (arb_active)
);

// File: tb/sim_can_arb_unit.sv
module sim_can_arb_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W   = 11;
    localparam int IDX_W  = 4;
    localparam int NVEC   = 8;

    // vector: [24:14] own id, [13] own rtr, [12:1] competitor {id,rtr}, [0] competitor present
    localparam logic [24:0] VECS [NVEC] = '{
        {11'h2A0, 1'b0, {11'h2B0, 1'b0}, 1'b1},
        {11'h2B0, 1'b0, {11'h2A0, 1'b0}, 1'b1},
        {11'h400, 1'b0, {11'h001, 1'b0}, 1'b1},
        {11'h123, 1'b1, {11'h123, 1'b0}, 1'b1},
        {11'h123, 1'b0, {11'h123, 1'b1}, 1'b1},
        {11'h7FF, 1'b1, {11'h000, 1'b0}, 1'b0},
        {11'h000, 1'b0, {11'h000, 1'b0}, 1'b1},
        {11'h0F1, 1'b0, {11'h0F0, 1'b1}, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_pt = 1'b0;
    logic             start_req = 1'b0;
    logic [ID_W-1:0]  frame_id = '0;
    logic             rtr_flag = 1'b0;
    logic             bus_rx = 1'b1;
    logic             bus_tx, bus_idle, lost, won;
    logic [IDX_W-1:0] lost_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_arb_unit u0 (
        .clk(clk), .rst_n(rst_n), .smp_pt(smp_pt), .start_req(start_req),
        .frame_id(frame_id), .rtr_flag(rtr_flag), .bus_rx(bus_rx),
        .bus_tx(bus_tx), .bus_idle(bus_idle), .lost(lost), .won(won),
        .lost_idx(lost_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic b);
        bus_rx = b;
        smp_pt = 1'b1;
        @(negedge clk);
        smp_pt = 1'b0;
        bus_rx = 1'b1;
    endtask

    task automatic go_idle();
        for (int i = 0; i < 11; i++) strobe(1'b1);
    endtask

    task automatic do_start(input logic [ID_W-1:0] id, input logic r);
        frame_id  = id;
        rtr_flag  = r;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic run_vec(input logic [24:0] v);
        logic [11:0] w, c;
        logic        present, comp_out, exp_lose, decided;
        int          exp_idx, first_k;
        w = v[24:13];
        c = v[12:1];
        present = v[0];
        // expected outcome from the priority rule: lowest {id,rtr} wins
        exp_lose = 1'b0; decided = 1'b0; first_k = 12; exp_idx = 0;
        if (present) begin
            for (int k = 0; k < 12; k++) begin
                if (!decided && w[11-k] != c[11-k]) begin
                    decided = 1'b1;
                    exp_lose = w[11-k];
                    first_k = k;
                end
            end
        end
        if (exp_lose) exp_idx = (first_k < 11) ? (10 - first_k) : 11;
        go_idle();
        do_start(w[11:1], w[0]);
        check("R8 clear lost", int'(lost), 0);
        check("R8 clear won", int'(won), 0);
        check("R8 clear idx", int'(lost_idx), 0);
        comp_out = !present;
        for (int k = 0; k < 12; k++) begin
            logic cb, b;
            check("R3/R4 bus_tx", int'(bus_tx),
                  (exp_lose && k > first_k) ? 1 : int'(w[11-k]));
            cb = comp_out ? 1'b1 : c[11-k];
            b = bus_tx & cb;
            if (cb && !b) comp_out = 1'b1;
            strobe(b);
        end
        check(present ? "R5/R6 lost" : "R7 lost", int'(lost), int'(exp_lose));
        check(present ? "R5/R6 won" : "R7 won", int'(won), int'(!exp_lose));
        check("R4 lost_idx", int'(lost_idx), exp_idx);
        check("R9 exclusive", int'(lost && won), 0);
        strobe(1'b0);
        strobe(1'b1);
        check("R8 hold lost", int'(lost), int'(exp_lose));
        check("R8 hold won", int'(won), int'(!exp_lose));
        check("R8 hold idx", int'(lost_idx), exp_idx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bus_tx", int'(bus_tx), 1);
        check("R1 lost", int'(lost), 0);
        check("R1 won", int'(won), 0);
        check("R1 lost_idx", int'(lost_idx), 0);
        check("R1 bus_idle", int'(bus_idle), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start before idle is ignored
        for (int i = 0; i < 5; i++) strobe(1'b1);
        do_start(11'h000, 1'b0);
        check("R2 ignored start bus_tx", int'(bus_tx), 1);
        for (int i = 0; i < 12; i++) strobe(1'b1);
        check("R2 ignored start won", int'(won), 0);

        // R2: idle boundary, with a dominant breaking the run
        strobe(1'b0);
        for (int i = 0; i < 10; i++) strobe(1'b1);
        check("R2 ten recessive", int'(bus_idle), 0);
        strobe(1'b1);
        check("R2 eleven recessive", int'(bus_idle), 1);
        strobe(1'b0);
        check("R2 dominant clears", int'(bus_idle), 0);

        // table-driven arbitration runs (R3..R9)
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule